// File: doc/BRIEF.md
# SD Command Issue Unit

This block is the command half of an SD/MMC host controller. Software reaches it through a small register window. It writes a 32-bit argument and a command word that carries the command index, a response-expected flag, a long-response flag and an application-command flag. When the start bit is set, the block hands the command to a simplified card-side interface. Transmission takes a fixed number of card clock ticks. The block then either finishes at once or waits for the card to answer.

The card side returns a 128-bit response word, the index it is answering and a flag that says whether the response CRC was good. Bit serialisation and CRC7 are not done here. Four sticky status bits report the outcome, and software clears each one by writing 1 to its position in a clear register. A good response is stored in four response registers, and the answered index is kept in a response-command register. The timeout is a programmable count of card clock ticks. A soft reset bit returns every register to its reset value and then clears itself.

Top module: `sd_cmd_unit`

## Requirements
- R1: After reset, the command, argument, response word, response-command and status registers read 0, and the timeout register (offset 0x20) reads TO_DEFAULT (64).
- R2: A write to offset 0x00 stores the index (bits 5:0), response-expected (bit 6), long (bit 7) and application (bit 8) fields. If bit 9 is also 1, card_send_o pulses high for exactly the cycle after the write, and card_idx_o, card_arg_o, card_need_rsp_o and card_long_o show the stored command.
- R3: Bit 9 of offset 0x00 reads 1 while a command is in flight and 0 once it finishes. While a command is in flight, writes to offsets 0x00 and 0x04 are ignored: the fields do not change and no new pulse is sent.
- R4: Without response-expected, status bit 6 (sent) is set after TX_TICKS (48) card ticks, and the response registers do not change.
- R5: With response-expected, bit 6 is set when transmission ends, and the block then waits for a response.
- R6: A response with good CRC sets status bit 4. For a short response, offset 0x08 takes rsp_data_i[31:0] and the other response words keep their values. Offset 0x18 takes the card's index in bits 5:0 and the issued command's application flag in bit 6.
- R7: A good long response stores rsp_data_i[127:96] at 0x08, [95:64] at 0x0C, [63:32] at 0x10 and [31:0] at 0x14.
- R8: A response with bad CRC sets status bit 0 and leaves the response and response-command registers unchanged.
- R9: If no response arrives within the number of card ticks held at offset 0x20, status bit 2 is set and the response registers do not change. Only cycles with card_tick_i high count.
- R10: Writing 1 to bit n of offset 0x2C clears status bit n (n = 0, 2, 4, 6). If the same bit is set in that cycle, the set wins.
- R11: Writing 1 to bit 10 of offset 0x00 aborts any command. Bit 10 then reads 1 for RST_CYCLES (4) cycles, during which every register holds its reset value and all register writes are ignored.
- R12: A response presented while no command is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| card_tick_i | input | 1 | One card clock tick |
| card_send_o | output | 1 | One-cycle pulse when a command starts |
| card_idx_o | output | 6 | Command index |
| card_arg_o | output | 32 | Command argument |
| card_need_rsp_o | output | 1 | Response expected |
| card_long_o | output | 1 | Long response expected |
| rsp_valid_i | input | 1 | Card response present |
| rsp_crc_ok_i | input | 1 | Response CRC good |
| rsp_index_i | input | 6 | Index echoed by the card |
| rsp_data_i | input | 32*RSP_WORDS | Response payload |

## Verification
A command without a response separates the early-finish path from the waiting path. A short good response checks the capture of word 0 alone and the application flag in the response-command register. A long good response checks the word order, and the bench issues a clear in the same cycle to test that the set wins. A bad-CRC response and a timeout with ticks present only every other cycle show that the response registers stay unchanged and that the timeout counts card ticks rather than clock cycles. A stray response while idle, start writes during a command, and a soft reset in mid-command show which stimuli the block must ignore.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} seq_st_e;

  localparam int OFS_CMD  = 0;
  localparam int OFS_ARG  = 4;
  localparam int OFS_RSP0 = 8;
  localparam int OFS_RCMD = 24;
  localparam int OFS_TMO  = 32;
  localparam int OFS_STAT = 40;
  localparam int OFS_CLR  = 44;

  localparam int CB_NEED = 6;
  localparam int CB_LONG = 7;
  localparam int CB_APP  = 8;
  localparam int CB_GO   = 9;
  localparam int CB_SRST = 10;

  // status vector index i maps to register bit 2*i: fail, timeout, ok, sent
  localparam int STAT_N = 4;
endpackage

// File: rtl/sd_cmd_srst.sv
module sd_cmd_srst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (req_i)         cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
#(
  parameter int TX_TICKS = 48,
  parameter int TO_W     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            start_i,
  input  logic            need_i,
  input  logic            tick_i,
  input  logic            rsp_valid_i,
  input  logic            rsp_ok_i,
  input  logic [TO_W-1:0] to_val_i,
  output logic            busy_o,
  output logic            send_o,
  output logic            ev_sent_o,
  output logic            ev_ok_o,
  output logic            ev_fail_o,
  output logic            ev_to_o
);
  localparam int TXC_W = $clog2(TX_TICKS + 1);
  localparam int CNT_W = ((TXC_W > TO_W) ? TXC_W : TO_W) + 1;

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             send_q;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    ev_sent_o = 1'b0;
    ev_ok_o   = 1'b0;
    ev_fail_o = 1'b0;
    ev_to_o   = 1'b0;
    if (srst_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_d  = ST_SEND;
          cnt_d = '0;
        end
        ST_SEND: if (tick_i) begin
          if (cnt_q == CNT_W'(TX_TICKS - 1)) begin
            ev_sent_o = 1'b1;
            st_d      = need_i ? ST_WAIT : ST_IDLE;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          // a response in the same cycle as the last tick beats the timeout
          if (rsp_valid_i) begin
            ev_ok_o   = rsp_ok_i;
            ev_fail_o = !rsp_ok_i;
            st_d      = ST_IDLE;
            cnt_d     = '0;
          end else if (tick_i) begin
            if ((cnt_q + 1'b1) >= CNT_W'(to_val_i)) begin
              ev_to_o = 1'b1;
              st_d    = ST_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      send_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      send_q <= start_i && !srst_i && (st_q == ST_IDLE);
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign send_o = send_q;
endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int TO_W       = 16,
  parameter int TO_DEFAULT = 64,
  parameter int RSP_WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    srst_i,
  input  logic                    rst_busy_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    seq_busy_i,
  input  logic                    ev_sent_i,
  input  logic                    ev_ok_i,
  input  logic                    ev_fail_i,
  input  logic                    ev_to_i,
  input  logic [5:0]              rsp_index_i,
  input  logic [32*RSP_WORDS-1:0] rsp_data_i,
  output logic [31:0]             rdata_o,
  output logic                    start_o,
  output logic [5:0]              idx_o,
  output logic [31:0]             arg_o,
  output logic                    need_o,
  output logic                    long_o,
  output logic [TO_W-1:0]         to_val_o,
  output logic                    stat_sent_o,
  output logic [31:0]             rsp0_o
);
  logic wr_cmd, wr_arg, wr_tmo, wr_clr;
  assign wr_cmd = wr_i && !rst_busy_i && (addr_i == ADDR_W'(OFS_CMD));
  assign wr_arg = wr_i && !rst_busy_i && (addr_i == ADDR_W'(OFS_ARG));
  assign wr_tmo = wr_i && !rst_busy_i && (addr_i == ADDR_W'(OFS_TMO));
  assign wr_clr = wr_i && !rst_busy_i && (addr_i == ADDR_W'(OFS_CLR));

  assign start_o = wr_cmd && wdata_i[CB_GO] && !wdata_i[CB_SRST] && !seq_busy_i;

  logic [5:0]      idx_q;
  logic            need_q, long_q, app_q;
  logic [31:0]     arg_q;
  logic [TO_W-1:0] to_q;
  logic [6:0]      rcmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || srst_i) begin
      idx_q  <= '0;
      need_q <= 1'b0;
      long_q <= 1'b0;
      app_q  <= 1'b0;
      arg_q  <= '0;
      to_q   <= TO_W'(TO_DEFAULT);
      rcmd_q <= '0;
    end else begin
      if (wr_cmd && !seq_busy_i) begin
        idx_q  <= wdata_i[5:0];
        need_q <= wdata_i[CB_NEED];
        long_q <= wdata_i[CB_LONG];
        app_q  <= wdata_i[CB_APP];
      end
      if (wr_arg && !seq_busy_i) arg_q <= wdata_i;
      if (wr_tmo)                to_q  <= wdata_i[TO_W-1:0];
      if (ev_ok_i)               rcmd_q <= {app_q, rsp_index_i};
    end
  end

  logic [STAT_N-1:0] ev_v, stat_w;
  assign ev_v = {ev_sent_i, ev_ok_i, ev_to_i, ev_fail_i};

  for (genvar i = 0; i < STAT_N; i++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          bit_q <= 1'b0;
      else if (srst_i)                      bit_q <= 1'b0;
      else if (ev_v[i])                     bit_q <= 1'b1;
      else if (wr_clr && wdata_i[2*i])      bit_q <= 1'b0;
    end
    assign stat_w[i] = bit_q;
  end

  logic [RSP_WORDS-1:0][31:0] rsp_w;

  // long: most significant word lands at the lowest offset
  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_rsp
    localparam int SRC = (RSP_WORDS - 1 - k) * 32;
    logic [31:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      w_q <= '0;
      else if (srst_i)  w_q <= '0;
      else if (ev_ok_i && (long_q || k == 0))
        w_q <= long_q ? rsp_data_i[SRC +: 32] : rsp_data_i[31:0];
    end
    assign rsp_w[k] = w_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CMD))
      rdata_o = {21'd0, rst_busy_i, seq_busy_i, app_q, long_q, need_q, idx_q};
    if (addr_i == ADDR_W'(OFS_ARG))  rdata_o = arg_q;
    if (addr_i == ADDR_W'(OFS_RCMD)) rdata_o = {25'd0, rcmd_q};
    if (addr_i == ADDR_W'(OFS_TMO))  rdata_o = 32'(to_q);
    for (int k = 0; k < RSP_WORDS; k++)
      if (addr_i == ADDR_W'(OFS_RSP0 + 4 * k)) rdata_o = rsp_w[k];
    if (addr_i == ADDR_W'(OFS_STAT))
      for (int i = 0; i < STAT_N; i++) rdata_o[2*i] = stat_w[i];
  end

  assign idx_o       = idx_q;
  assign arg_o       = arg_q;
  assign need_o      = need_q;
  assign long_o      = long_q;
  assign to_val_o    = to_q;
  assign stat_sent_o = stat_w[3];
  assign rsp0_o      = rsp_w[0];
endmodule

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int TX_TICKS   = 48,
  parameter int TO_W       = 16,
  parameter int TO_DEFAULT = 64,
  parameter int RST_CYCLES = 4,
  parameter int RSP_WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  input  logic                    card_tick_i,
  output logic                    card_send_o,
  output logic [5:0]              card_idx_o,
  output logic [31:0]             card_arg_o,
  output logic                    card_need_rsp_o,
  output logic                    card_long_o,
  input  logic                    rsp_valid_i,
  input  logic                    rsp_crc_ok_i,
  input  logic [5:0]              rsp_index_i,
  input  logic [32*RSP_WORDS-1:0] rsp_data_i
);
  logic            rst_busy, srst_req, srst_all;
  logic            seq_busy, start, need;
  logic            ev_sent, ev_ok, ev_fail, ev_to;
  logic [TO_W-1:0] to_val;
  logic            stat_sent;
  logic [31:0]     rsp0_w;

  assign srst_req = reg_wr_i && !rst_busy && (reg_addr_i == ADDR_W'(OFS_CMD))
                    && reg_wdata_i[CB_SRST];
  assign srst_all = srst_req || rst_busy;

  sd_cmd_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (srst_req),
    .busy_o(rst_busy)
  );

  sd_cmd_seq #(.TX_TICKS(TX_TICKS), .TO_W(TO_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_all),
    .start_i    (start),
    .need_i     (need),
    .tick_i     (card_tick_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ok_i   (rsp_crc_ok_i),
    .to_val_i   (to_val),
    .busy_o     (seq_busy),
    .send_o     (card_send_o),
    .ev_sent_o  (ev_sent),
    .ev_ok_o    (ev_ok),
    .ev_fail_o  (ev_fail),
    .ev_to_o    (ev_to)
  );

  sd_cmd_regs #(
    .ADDR_W(ADDR_W), .TO_W(TO_W), .TO_DEFAULT(TO_DEFAULT), .RSP_WORDS(RSP_WORDS)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_all),
    .rst_busy_i (rst_busy),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .seq_busy_i (seq_busy),
    .ev_sent_i  (ev_sent),
    .ev_ok_i    (ev_ok),
    .ev_fail_i  (ev_fail),
    .ev_to_i    (ev_to),
    .rsp_index_i(rsp_index_i),
    .rsp_data_i (rsp_data_i),
    .rdata_o    (reg_rdata_o),
    .start_o    (start),
    .idx_o      (card_idx_o),
    .arg_o      (card_arg_o),
    .need_o     (need),
    .long_o     (card_long_o),
    .to_val_o   (to_val),
    .stat_sent_o(stat_sent),
    .rsp0_o     (rsp0_w)
  );

  assign card_need_rsp_o = need;
endmodule

// File: rtl/sd_cmd_unit_chk.sv
module sd_cmd_unit_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wd_srst,
  input logic              wd_clr_sent,
  input logic              card_send_o,
  input logic [5:0]        card_idx_o,
  input logic              seq_busy,
  input logic              rst_busy,
  input logic              ev_sent,
  input logic              ev_ok,
  input logic              ev_fail,
  input logic              ev_to,
  input logic              stat_sent,
  input logic [31:0]       rsp0_w
);
  p_send_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_send_o |=> !card_send_o);

  p_go_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && reg_wr_i && reg_addr_i == ADDR_W'(0) && !wd_srst)
    |=> (!card_send_o && $stable(card_idx_o)));

  p_one_outcome_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_ok, ev_fail, ev_to}));

  p_fail_keeps_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_fail |=> $stable(rsp0_w));

  p_to_in_flight_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_to |-> seq_busy);

  p_clear_sent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(44) && wd_clr_sent && !ev_sent && !rst_busy)
    |=> !stat_sent);

  p_srst_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy |-> !seq_busy);
endmodule

bind sd_cmd_unit sd_cmd_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .wd_srst    (reg_wdata_i[10]),
  .wd_clr_sent(reg_wdata_i[6]),
  .card_send_o(card_send_o),
  .card_idx_o (card_idx_o),
  .seq_busy   (seq_busy),
  .rst_busy   (rst_busy),
  .ev_sent    (ev_sent),
  .ev_ok      (ev_ok),
  .ev_fail    (ev_fail),
  .ev_to      (ev_to),
  .stat_sent  (stat_sent),
  .rsp0_w     (rsp0_w)
);

// File: tb/sd_cmd_unit_tb.sv
module sd_cmd_unit_tb;
  localparam int TX    = 48;
  localparam int RSTC  = 4;
  localparam int TODEF = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         tick = 1'b1;
  logic         send;
  logic [5:0]   cidx;
  logic [31:0]  carg;
  logic         cneed, clong;
  logic         rv = 1'b0, rok = 1'b0;
  logic [5:0]   ridx = '0;
  logic [127:0] rdat = '0;
  bit           tick_tog = 1'b0;
  bit           done = 1'b0;
  int           checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  sd_cmd_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .card_tick_i(tick),
    .card_send_o(send), .card_idx_o(cidx), .card_arg_o(carg),
    .card_need_rsp_o(cneed), .card_long_o(clong), .rsp_valid_i(rv),
    .rsp_crc_ok_i(rok), .rsp_index_i(ridx), .rsp_data_i(rdat)
  );

  // behavioural reference model
  int          m_st, m_cnt, m_rst;
  logic [5:0]  m_idx;
  logic        m_need, m_long, m_app, m_send;
  logic [31:0] m_arg;
  logic [31:0] m_rsp [4];
  logic [6:0]  m_rcmd;
  logic [15:0] m_to;
  logic [3:0]  m_stat;

  task automatic m_clear();
    m_st = 0; m_cnt = 0; m_idx = '0; m_need = 0; m_long = 0; m_app = 0;
    m_send = 0; m_arg = '0; m_rcmd = '0; m_to = 16'(TODEF); m_stat = '0;
    for (int k = 0; k < 4; k++) m_rsp[k] = '0;
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'd0:  return {21'd0, m_rst != 0, m_st != 0, m_app, m_long, m_need, m_idx};
      6'd4:  return m_arg;
      6'd8:  return m_rsp[0];
      6'd12: return m_rsp[1];
      6'd16: return m_rsp[2];
      6'd20: return m_rsp[3];
      6'd24: return {25'd0, m_rcmd};
      6'd32: return {16'd0, m_to};
      6'd40: return {25'd0, m_stat[3], 1'b0, m_stat[2], 1'b0, m_stat[1], 1'b0, m_stat[0]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    bit wc, es, eo, ef, et, ns;
    int st_n;
    if (!rst_n) begin
      m_clear();
      m_rst = 0;
    end else begin
      wc = wr && addr == 6'd0;
      if (m_rst == 0 && wc && wdata[10]) begin
        m_clear();
        m_rst = RSTC;
      end else if (m_rst != 0) begin
        m_rst = m_rst - 1;
      end else begin
        es = 0; eo = 0; ef = 0; et = 0; ns = 0; st_n = m_st;
        case (m_st)
          0: if (wc && wdata[9] && !wdata[10]) begin st_n = 1; m_cnt = 0; ns = 1; end
          1: if (tick) begin
               if (m_cnt == TX - 1) begin es = 1; st_n = m_need ? 2 : 0; m_cnt = 0; end
               else m_cnt = m_cnt + 1;
             end
          default: if (rv) begin
               eo = rok; ef = !rok; st_n = 0; m_cnt = 0;
             end else if (tick) begin
               if (m_cnt + 1 >= int'(m_to)) begin et = 1; st_n = 0; m_cnt = 0; end
               else m_cnt = m_cnt + 1;
             end
        endcase
        if (eo) begin
          if (m_long) for (int k = 0; k < 4; k++) m_rsp[k] = rdat[32*(3-k) +: 32];
          else m_rsp[0] = rdat[31:0];
          m_rcmd = {m_app, ridx};
        end
        if (wr && addr == 6'd44) m_stat = m_stat & ~{wdata[6], wdata[4], wdata[2], wdata[0]};
        m_stat = m_stat | {es, eo, et, ef};
        if (wc && m_st == 0 && !wdata[10]) begin
          m_idx = wdata[5:0]; m_need = wdata[6]; m_long = wdata[7]; m_app = wdata[8];
        end
        if (wr && addr == 6'd4 && m_st == 0) m_arg = wdata;
        if (wr && addr == 6'd32) m_to = wdata[15:0];
        m_st = st_n;
        m_send = ns;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic string addr_tag(input logic [5:0] a);
    case (a)
      6'd0: return "R3";
      6'd4: return "R2";
      6'd32: return "R9";
      6'd40: return "R10";
      default: return (a >= 6'd8 && a <= 6'd24) ? "R6" : "R1";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #5;
      chk(addr_tag(addr), rdata, m_read(addr));
      chk("R2 send", 32'(send), 32'(m_send));
      chk("R2 idx", 32'(cidx), 32'(m_idx));
      chk("R2 arg", carg, m_arg);
      chk("R2 flags", {30'd0, cneed, clong}, {30'd0, m_need, m_long});
    end
  end

  always @(negedge clk) if (tick_tog) tick = ~tick;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); addr = a;
    #5 chk(r, rdata, exp);
  endtask

  task automatic wait_st(input int s);
    while (m_st != s) @(negedge clk);
  endtask

  task automatic respond(input logic ok, input logic [5:0] ix, input logic [127:0] d);
    @(negedge clk); rv = 1; rok = ok; ridx = ix; rdat = d;
    @(negedge clk); rv = 0;
  endtask

  localparam logic [127:0] LONGD = 128'h11112222_33334444_55556666_77778888;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk(6'd0, 32'd0, "R1");
    rd_chk(6'd4, 32'd0, "R1");
    rd_chk(6'd8, 32'd0, "R1");
    rd_chk(6'd24, 32'd0, "R1");
    rd_chk(6'd32, 32'd64, "R1");
    rd_chk(6'd40, 32'd0, "R1");

    wr_reg(6'd4, 32'h1234_5678);
    wr_reg(6'd32, 32'd20);

    // R4 no-response command, index 0
    wr_reg(6'd0, 32'h200);
    #5 chk("R2 pulse", 32'(send), 32'd1);
    wait_st(0);
    rd_chk(6'd40, 32'h40, "R4");
    rd_chk(6'd8, 32'd0, "R4");
    rd_chk(6'd0, 32'd0, "R3 self-clear");

    // R10 clear
    wr_reg(6'd44, 32'h40);
    rd_chk(6'd40, 32'd0, "R10");

    // R5/R6 short response, index 17, app
    wr_reg(6'd0, 32'h351);
    #5 chk("R2 idx", 32'(cidx), 32'd17);
    chk("R2 arg", carg, 32'h1234_5678);
    chk("R2 need", 32'(cneed), 32'd1);
    rd_chk(6'd0, 32'h351, "R3 busy");
    wr_reg(6'd0, 32'h205);
    #5 chk("R3 no pulse", 32'(send), 32'd0);
    rd_chk(6'd0, 32'h351, "R3");
    wr_reg(6'd4, 32'h0000_dead);
    rd_chk(6'd4, 32'h1234_5678, "R3");
    wait_st(2);
    rd_chk(6'd40, 32'h40, "R5");
    respond(1'b1, 6'd17, {96'd0, 32'hCAFE_F00D});
    rd_chk(6'd40, 32'h50, "R6");
    rd_chk(6'd8, 32'hCAFE_F00D, "R6");
    rd_chk(6'd12, 32'd0, "R6");
    rd_chk(6'd24, 32'h51, "R6");

    // R7 long response with same-cycle clear of bit 4 (R10 set wins)
    wr_reg(6'd44, 32'h55);
    wr_reg(6'd0, 32'h2C2);
    wait_st(2);
    @(negedge clk); wr = 1; addr = 6'd44; wdata = 32'h10;
    rv = 1; rok = 1; ridx = 6'd2; rdat = LONGD;
    @(negedge clk); wr = 0; rv = 0;
    rd_chk(6'd40, 32'h50, "R10 set wins");
    rd_chk(6'd8, 32'h1111_2222, "R7");
    rd_chk(6'd12, 32'h3333_4444, "R7");
    rd_chk(6'd16, 32'h5555_6666, "R7");
    rd_chk(6'd20, 32'h7777_8888, "R7");
    rd_chk(6'd24, 32'h02, "R7");

    // R8 bad CRC
    wr_reg(6'd44, 32'h55);
    wr_reg(6'd0, 32'h243);
    wait_st(2);
    respond(1'b0, 6'd3, {128{1'b1}});
    rd_chk(6'd40, 32'h41, "R8");
    rd_chk(6'd8, 32'h1111_2222, "R8");
    rd_chk(6'd24, 32'h02, "R8");

    // R9 timeout with ticks every other cycle
    wr_reg(6'd44, 32'h55);
    wr_reg(6'd32, 32'd5);
    tick_tog = 1;
    wr_reg(6'd0, 32'h249);
    wait_st(2);
    n = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); addr = 6'd40;
      #5;
      if (rdata[2]) begin n = i; break; end
    end
    chk("R9 ticks", 32'(n >= 7 && n <= 12), 32'd1);
    tick_tog = 0;
    @(negedge clk); tick = 1;
    rd_chk(6'd40, 32'h44, "R9");
    rd_chk(6'd8, 32'h1111_2222, "R9");

    // R12 stray response while idle
    respond(1'b1, 6'd40, {96'd0, 32'hABAB_ABAB});
    rd_chk(6'd40, 32'h44, "R12");
    rd_chk(6'd8, 32'h1111_2222, "R12");
    rd_chk(6'd24, 32'h02, "R12");

    // R11 soft reset in mid-command
    wr_reg(6'd0, 32'h201);
    repeat (3) @(negedge clk);
    wr_reg(6'd0, 32'h400);
    rd_chk(6'd0, 32'h400, "R11");
    wr_reg(6'd4, 32'h77);
    repeat (6) @(negedge clk);
    rd_chk(6'd0, 32'd0, "R11");
    rd_chk(6'd4, 32'd0, "R11");
    rd_chk(6'd32, 32'd64, "R11");
    rd_chk(6'd40, 32'd0, "R11");
    rd_chk(6'd8, 32'd0, "R11");

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule